// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a synchronous host and an 8192 x 8 asynchronous static RAM. The RAM has no clock. It responds to two chip enables of opposite polarity, an active-low write strobe, an active-low output enable and one shared data bus. The host issues single-beat requests through a valid/ready handshake that carries an address, a write flag and write data. The controller turns each request into a timed pin sequence on the RAM side. It counts clock cycles to do this, and every cycle count is derived from a nanosecond figure and the clock period parameter.

The data bus is split into an output value, an output-enable and an input value. The surrounding pad logic forms the tri-state bus from these. The controller never drives that bus while the RAM might still be driving it. It drops its own drive no later than the cycle in which the write strobe rises.

The controller also guards the RAM during power-up. The active-high chip enable stays low and no request is accepted until the power-good input has been high for one full memory cycle time. Losing power-good aborts the access in flight and parks the RAM in standby.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is asserted the RAM pins rest idle: active-low enable, write strobe and output enable are all 1, the active-high enable is 0, data drive is off, and both ready and read-valid are 0.
- R2: The active-high enable and request-ready stay 0 until power-good has been sampled high on LOCK consecutive clock edges, where LOCK = ceil(150 ns / period). A single low sample restarts the count.
- R3: On the edge that samples power-good low, the active-high enable goes to 0, the active-low enable goes to 1, the write strobe goes to 1 and data drive turns off. An access in flight is dropped and produces no read-valid pulse.
- R4: Ready is 1 only in idle with power locked. A request is taken on an edge where valid and ready are both 1. Ready then stays 0 for 1 + WP + WR cycles after a write and for RD + TZ cycles after a read.
- R5: A write drives the address and data with the strobe high for one cycle. It then holds the strobe low for WP = max(ceil(90/period), ceil(60/period) - 1) cycles with data driven and both enables asserted. Data drive turns off in the same cycle that the strobe rises.
- R6: While the active-low enable is 0 the address does not change. The write recovery phase lasts WR = max(ceil(10/period), ceil(150/period) - 1 - WP) cycles with the enable still asserted, so that a full write takes at least ceil(150/period) cycles.
- R7: A read holds the active-low enable at 0, the output enable at 0 and the strobe at 1 for RD = max(ceil(150/period), ceil(70/period)) cycles.
- R8: Read-valid is a one-cycle pulse in the cycle after the last read cycle. Read data equals the bus value sampled at the end of that last read cycle.
- R9: After a read, both enables are released and data drive stays off for TZ = ceil(50/period) cycles before the controller returns to idle, so the controller never drives the bus while the RAM may still be driving it.
- R10: Every phase length is ceil(ns / CLK_PERIOD_NS), with a minimum of one cycle.
- R11: The write strobe and the output enable are never both 0, and data drive is on only while the output enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Supply at operating level (synchronous) |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Word address |
| req_wdata | input | 8 | Write data |
| rd_valid | output | 1 | One-cycle read return pulse |
| rd_data | output | 8 | Read return data |
| sram_addr | output | 13 | RAM address pins |
| sram_dq_o | output | 8 | Value to drive on the RAM data bus |
| sram_dq_oe | output | 1 | Drive enable for the RAM data bus |
| sram_dq_i | input | 8 | Value seen on the RAM data bus |
| sram_ce_n | output | 1 | Active-low chip enable |
| sram_ce | output | 1 | Active-high chip enable (power lockout) |
| sram_we_n | output | 1 | Active-low write strobe |
| sram_oe_n | output | 1 | Active-low output enable |

## Verification
The bench's RAM model returns the inverted word whenever the address has been stable for less than the access time or the output enable has been low for less than its access time. A read phase that is one cycle too short therefore shows up as wrong data, not as silent success. The model also counts strobe width and data age at each strobe rise, and it tracks how long the RAM keeps driving the bus after a read. A controller with a short write pulse, late data release, or a missing turnaround is reported at the exact cycle of the fault. Directed cases cover the power lock and its restart after a power-good glitch, an abort in the middle of a read, back-to-back requests held valid, and the two extreme addresses with all-zero and all-one data. A lock counter off by one would surface as a wrong ready cycle. An abort that still completes would surface as a stray read-valid pulse.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WSET = 3'd1,
    ST_WPUL = 3'd2,
    ST_WREC = 3'd3,
    ST_READ = 3'd4,
    ST_TURN = 3'd5
  } phase_e;

  typedef struct packed {
    logic ce_n;
    logic we_n;
    logic oe_n;
    logic drive;
  } pins_t;

  // Nanoseconds to clock cycles, rounded up, never below one cycle.
  function automatic int unsigned ns2cyc(int unsigned ns, int unsigned per);
    int unsigned c;
    c = (ns + per - 1) / per;
    if (c == 0) c = 1;
    return c;
  endfunction

  function automatic int unsigned umax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_pwr_gate.sv
`timescale 1ns/1ps
// Power lockout: pwr_ok rises after LOCK consecutive high samples of pwr_good.
module sram_pwr_gate #(
  parameter int unsigned LOCK = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good,
  output logic pwr_ok
);
  localparam int unsigned CW = $clog2(LOCK + 1);

  logic [CW-1:0] stable_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stable_cnt <= '0;
    end else if (!pwr_good) begin
      stable_cnt <= '0;
    end else if (stable_cnt != CW'(LOCK)) begin
      stable_cnt <= stable_cnt + 1'b1;
    end
  end

  assign pwr_ok = (stable_cnt == CW'(LOCK));

endmodule

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
// Down counter: load (length-1) on phase entry; expired marks the final cycle.
module sram_phase_timer #(
  parameter int unsigned TW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);
  logic [TW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
    end else if (load) begin
      remain <= load_val;
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign expired = (remain == '0);

endmodule

// File: rtl/sram_pin_decode.sv
`timescale 1ns/1ps
// Pin levels for each phase of the access sequence.
module sram_pin_decode
  import sram_ctrl_pkg::*;
(
  input  phase_e phase,
  output pins_t  pins
);
  always_comb begin
    pins = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};
    unique case (phase)
      ST_WSET: pins = '{ce_n: 1'b0, we_n: 1'b1, oe_n: 1'b1, drive: 1'b1};
      ST_WPUL: pins = '{ce_n: 1'b0, we_n: 1'b0, oe_n: 1'b1, drive: 1'b1};
      ST_WREC: pins = '{ce_n: 1'b0, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};
      ST_READ: pins = '{ce_n: 1'b0, we_n: 1'b1, oe_n: 1'b0, drive: 1'b0};
      default: pins = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};
    endcase
  end
endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 5,
  parameter int unsigned ADDR_W        = 13,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned T_CYCLE_NS    = 150,
  parameter int unsigned T_ACC_NS      = 150,
  parameter int unsigned T_OE_ACC_NS   = 70,
  parameter int unsigned T_OE_HIZ_NS   = 50,
  parameter int unsigned T_WP_NS       = 90,
  parameter int unsigned T_WREC_NS     = 10,
  parameter int unsigned T_DS_NS       = 60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_good,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_i,
  output logic              sram_ce_n,
  output logic              sram_ce,
  output logic              sram_we_n,
  output logic              sram_oe_n
);
  // Cycle counts derived from the nanosecond figures.
  localparam int unsigned C_CYC  = ns2cyc(T_CYCLE_NS,  CLK_PERIOD_NS);
  localparam int unsigned C_ACC  = ns2cyc(T_ACC_NS,    CLK_PERIOD_NS);
  localparam int unsigned C_OEA  = ns2cyc(T_OE_ACC_NS, CLK_PERIOD_NS);
  localparam int unsigned C_HIZ  = ns2cyc(T_OE_HIZ_NS, CLK_PERIOD_NS);
  localparam int unsigned C_WP   = ns2cyc(T_WP_NS,     CLK_PERIOD_NS);
  localparam int unsigned C_WR   = ns2cyc(T_WREC_NS,   CLK_PERIOD_NS);
  localparam int unsigned C_DS   = ns2cyc(T_DS_NS,     CLK_PERIOD_NS);

  // Phase lengths. Data is driven from the setup cycle on, so the pulse
  // only has to cover the data setup minus that one cycle.
  localparam int unsigned LEN_WSET = 1;
  localparam int unsigned LEN_WPUL = umax(C_WP, (C_DS > 1) ? C_DS - 1 : 1);
  localparam int unsigned LEN_WREC = umax(C_WR,
      (C_CYC > 1 + LEN_WPUL) ? C_CYC - 1 - LEN_WPUL : 1);
  localparam int unsigned LEN_READ = umax(C_CYC, umax(C_ACC, C_OEA));
  localparam int unsigned LEN_TURN = C_HIZ;
  localparam int unsigned LEN_MAX  = umax(umax(LEN_WPUL, LEN_WREC),
                                          umax(LEN_READ, LEN_TURN));
  localparam int unsigned TW       = $clog2(LEN_MAX + 1);

  function automatic logic [TW-1:0] phase_len(phase_e p);
    int unsigned len;
    unique case (p)
      ST_WSET: len = LEN_WSET;
      ST_WPUL: len = LEN_WPUL;
      ST_WREC: len = LEN_WREC;
      ST_READ: len = LEN_READ;
      ST_TURN: len = LEN_TURN;
      default: len = 1;
    endcase
    return TW'(len - 1);
  endfunction

  // Named internal events (observed by the bound checker).
  phase_e            phase_q, phase_nx;
  logic              pwr_ok;
  logic              phase_done;
  logic              acc_accept;
  logic              rd_capture;
  logic              we_release;
  logic              timer_load;
  logic [TW-1:0]     timer_val;
  pins_t             pins;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              rd_valid_q;
  logic [DATA_W-1:0] rd_data_q;

  sram_pwr_gate #(.LOCK(C_CYC)) u_pwr (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_good (pwr_good),
    .pwr_ok   (pwr_ok)
  );

  sram_phase_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (timer_load),
    .load_val (timer_val),
    .expired  (phase_done)
  );

  sram_pin_decode u_pins (
    .phase (phase_q),
    .pins  (pins)
  );

  assign req_ready  = (phase_q == ST_IDLE) && pwr_ok && pwr_good;
  assign acc_accept = req_ready && req_valid;
  assign rd_capture = (phase_q == ST_READ) && phase_done && pwr_good;
  assign we_release = (phase_q == ST_WPUL) && phase_done;

  always_comb begin
    phase_nx = phase_q;
    unique case (phase_q)
      ST_IDLE: if (acc_accept) phase_nx = req_write ? ST_WSET : ST_READ;
      ST_WSET: if (phase_done) phase_nx = ST_WPUL;
      ST_WPUL: if (phase_done) phase_nx = ST_WREC;
      ST_WREC: if (phase_done) phase_nx = ST_IDLE;
      ST_READ: if (phase_done) phase_nx = ST_TURN;
      ST_TURN: if (phase_done) phase_nx = ST_IDLE;
      default: phase_nx = ST_IDLE;
    endcase
    if (!pwr_good) phase_nx = ST_IDLE;
  end

  assign timer_load = (phase_nx != phase_q);
  assign timer_val  = phase_len(phase_nx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= ST_IDLE;
      addr_q     <= '0;
      wdata_q    <= '0;
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      phase_q    <= phase_nx;
      rd_valid_q <= rd_capture;
      if (acc_accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (rd_capture) rd_data_q <= sram_dq_i;
    end
  end

  assign rd_valid   = rd_valid_q;
  assign rd_data    = rd_data_q;
  assign sram_addr  = addr_q;
  assign sram_dq_o  = wdata_q;
  assign sram_dq_oe = pins.drive;
  assign sram_ce_n  = pins.ce_n;
  assign sram_we_n  = pins.we_n;
  assign sram_oe_n  = pins.oe_n;
  assign sram_ce    = pwr_ok;

endmodule

// File: rtl/sram_async_ctrl_chk.sv
`timescale 1ns/1ps
module sram_async_ctrl_chk #(
  parameter int unsigned ADDR_W  = 13,
  parameter int unsigned WP_CYC  = 18,
  parameter int unsigned HIZ_CYC = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pwr_good,
  input logic              req_ready,
  input logic              rd_valid,
  input logic              rd_capture,
  input logic              we_release,
  input logic [ADDR_W-1:0] sram_addr,
  input logic              sram_ce_n,
  input logic              sram_ce,
  input logic              sram_we_n,
  input logic              sram_oe_n,
  input logic              sram_dq_oe
);
  localparam int unsigned WW = $clog2(WP_CYC + 2);
  localparam int unsigned HW = $clog2(HIZ_CYC + 2);

  logic [WW-1:0] we_low_cnt;
  logic [HW-1:0] oe_high_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_low_cnt  <= '0;
      oe_high_cnt <= '1;
    end else begin
      if (!sram_we_n) begin
        if (we_low_cnt != '1) we_low_cnt <= we_low_cnt + 1'b1;
      end else begin
        we_low_cnt <= '0;
      end
      if (!sram_oe_n) oe_high_cnt <= '0;
      else if (oe_high_cnt != '1) oe_high_cnt <= oe_high_cnt + 1'b1;
    end
  end

  a_r1_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe));

  a_r2_enable_after_power: assert property (@(posedge clk) disable iff (!rst_n)
    sram_ce |-> $past(pwr_good));

  a_r3_power_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> (!sram_ce && sram_ce_n && sram_we_n && !sram_dq_oe));

  a_r5_strobe_enables: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> (!sram_ce_n && sram_ce && sram_dq_oe));

  a_r5_release_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> !sram_dq_oe);

  a_r5_release_event: assert property (@(posedge clk) disable iff (!rst_n)
    (we_release && pwr_good) |=> sram_we_n);

  a_r5_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_we_n && we_low_cnt != '0) |-> (we_low_cnt >= WW'(WP_CYC)));

  a_r6_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr));

  a_r8_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  a_r8_capture_returns: assert property (@(posedge clk) disable iff (!rst_n)
    rd_capture |=> rd_valid);

  a_r9_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> (oe_high_cnt >= HW'(HIZ_CYC)));

  a_r11_strobe_vs_oe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!sram_we_n && !sram_oe_n));

endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(
  .ADDR_W  (ADDR_W),
  .WP_CYC  (LEN_WPUL),
  .HIZ_CYC (LEN_TURN)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pwr_good   (pwr_good),
  .req_ready  (req_ready),
  .rd_valid   (rd_valid),
  .rd_capture (rd_capture),
  .we_release (we_release),
  .sram_addr  (sram_addr),
  .sram_ce_n  (sram_ce_n),
  .sram_ce    (sram_ce),
  .sram_we_n  (sram_we_n),
  .sram_oe_n  (sram_oe_n),
  .sram_dq_oe (sram_dq_oe)
);

// File: tb/sram_async_ctrl_tb.sv
`timescale 1ns/1ps
module sram_async_ctrl_tb;
  localparam int P = 5;

  // Cycle counts restated by counting up rather than dividing.
  function automatic int cyc(int ns);
    int c = 0;
    while (c * P < ns) c++;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int B_CYC = 30;
  int b_wp, b_wr, b_rd, b_tz, w_tot, r_tot;

  logic        clk = 1'b0;
  logic        rst_n, pwr_good, req_valid, req_write;
  logic [12:0] req_addr;
  logic [7:0]  req_wdata;
  logic        req_ready, rd_valid;
  logic [7:0]  rd_data;
  logic [12:0] sram_addr;
  logic [7:0]  sram_dq_o, bus_in, ram_q;
  logic        sram_dq_oe, sram_ce_n, sram_ce, sram_we_n, sram_oe_n;
  logic        ram_drive;

  always #2.5 clk = ~clk;

  assign bus_in = ram_drive ? ram_q : (sram_dq_oe ? sram_dq_o : 8'h00);

  sram_async_ctrl #(.CLK_PERIOD_NS(P)) u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .sram_addr(sram_addr), .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe),
    .sram_dq_i(bus_in), .sram_ce_n(sram_ce_n), .sram_ce(sram_ce),
    .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n)
  );

  int vectors = 0;
  int misses  = 0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Memories: bench reference and RAM model, both seeded by the same rule.
  logic [7:0] ref_mem [int];
  logic [7:0] mdl_mem [int];
  function automatic logic [7:0] seed_val(int a);
    return 8'(a) ^ 8'(a >> 5) ^ 8'h5C;
  endfunction
  function automatic logic [7:0] ref_rd(int a);
    return ref_mem.exists(a) ? ref_mem[a] : seed_val(a);
  endfunction
  function automatic logic [7:0] mdl_rd(int a);
    return mdl_mem.exists(a) ? mdl_mem[a] : seed_val(a);
  endfunction

  // Behavioural RAM model with timing checks, sampled on falling edges.
  logic        p_we_n, p_ce_n, p_dq_oe;
  logic [12:0] p_addr;
  logic [7:0]  p_dq_o;
  int we_cnt, data_age, addr_age, oe_age, hold, post_we, since_start;

  always @(negedge clk) begin
    bit read_en;
    if (!rst_n) begin
      p_we_n = 1; p_ce_n = 1; p_dq_oe = 0; p_addr = 0; p_dq_o = 0;
      we_cnt = 0; data_age = 0; addr_age = 0; oe_age = 0; hold = 0;
      post_we = 0; since_start = 1000; ram_drive = 0; ram_q = 0;
    end else begin
      read_en = !sram_ce_n && sram_ce && sram_we_n && !sram_oe_n;
      if (sram_dq_oe && (read_en || hold > 0))
        check(0, "R9", "bus contention", 1, 0);
      if (!sram_we_n && !sram_oe_n)
        check(0, "R11", "strobe and output enable both low", 1, 0);
      if (sram_addr != p_addr) begin
        if (!p_ce_n || post_we > 0)
          check(0, "R6", "address moved inside access", int'(sram_addr), int'(p_addr));
        addr_age = 1;
      end else addr_age++;
      if (p_ce_n && !sram_ce_n) begin
        if (since_start < B_CYC) check(0, "R6", "cycle time", since_start, B_CYC);
        since_start = 1;
      end else if (since_start < 1000) since_start++;
      if (!p_we_n && sram_we_n) begin
        check(we_cnt >= cyc(90), "R5", "strobe width", we_cnt, cyc(90));
        check(data_age >= cyc(60), "R5", "data setup", data_age, cyc(60));
        check(!sram_dq_oe, "R5", "drive after strobe rise", int'(sram_dq_oe), 0);
        mdl_mem[int'(p_addr)] = p_dq_o;
        post_we = cyc(10);
      end else if (post_we > 0) post_we--;
      if (!sram_we_n) begin
        if (sram_ce_n || !sram_ce) check(0, "R5", "strobe without enables", 1, 0);
        we_cnt++;
      end else we_cnt = 0;
      if (sram_dq_oe) data_age = (p_dq_oe && sram_dq_o == p_dq_o) ? data_age + 1 : 1;
      else data_age = 0;
      oe_age = read_en ? oe_age + 1 : 0;
      if (read_en) hold = cyc(50); else if (hold > 0) hold--;
      ram_drive = read_en;
      ram_q = (addr_age >= cyc(150) && oe_age >= cyc(70)) ?
              mdl_rd(int'(sram_addr)) : ~mdl_rd(int'(sram_addr));
      p_we_n = sram_we_n; p_ce_n = sram_ce_n; p_dq_oe = sram_dq_oe;
      p_addr = sram_addr; p_dq_o = sram_dq_o;
    end
  end

  // One request from a falling edge to the falling edge where ready returns.
  task automatic run_op(bit wr, logic [12:0] a, logic [7:0] d);
    int n, rv_at, rv_cnt;
    logic [7:0] got = 0;
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    n = 1; rv_cnt = 0; rv_at = -1;
    while (!req_ready && n < 400) begin
      if (rd_valid) begin rv_cnt++; rv_at = n; got = rd_data; end
      @(negedge clk);
      n++;
    end
    if (rd_valid) rv_cnt++;
    if (wr) begin
      check(n == w_tot + 1, "R4", "write occupancy (R10 counts)", n - 1, w_tot);
      check(rv_cnt == 0, "R8", "read-valid on a write", rv_cnt, 0);
      ref_mem[int'(a)] = d;
    end else begin
      check(n == r_tot + 1, "R4", "read occupancy (R10 counts)", n - 1, r_tot);
      check(rv_cnt == 1 && rv_at == b_rd + 1, "R7", "read phase length / pulse",
            rv_at, b_rd + 1);
      check(got == ref_rd(int'(a)), "R8", "read data", int'(got), int'(ref_rd(int'(a))));
    end
  endtask

  initial begin
    b_wp  = mx(cyc(90), cyc(60) - 1);
    b_wr  = mx(cyc(10), B_CYC - 1 - b_wp);
    b_rd  = mx(cyc(150), cyc(70));
    b_tz  = cyc(50);
    w_tot = 1 + b_wp + b_wr;
    r_tot = b_rd + b_tz;
  end

  initial begin
    int n, seed, rv_seen;
    seed = int'($urandom(32'h00C0FFEE));
    rst_n = 0; pwr_good = 0; req_valid = 0; req_write = 0;
    req_addr = 0; req_wdata = 0;
    repeat (3) @(negedge clk);
    check(sram_ce_n && sram_we_n && sram_oe_n, "R1", "strobes idle in reset",
          int'({sram_ce_n, sram_we_n, sram_oe_n}), 7);
    check(!sram_ce && !sram_dq_oe && !req_ready && !rd_valid, "R1",
          "enable/drive/ready in reset",
          int'({sram_ce, sram_dq_oe, req_ready, rd_valid}), 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    check(!sram_ce && !req_ready, "R2", "locked without power",
          int'({sram_ce, req_ready}), 0);

    // R2: lock with a glitch that restarts the count.
    pwr_good = 1;
    repeat (10) @(negedge clk);
    pwr_good = 0;
    @(negedge clk);
    check(!sram_ce && !req_ready, "R2", "glitch keeps lock", int'(sram_ce), 0);
    pwr_good = 1;
    n = 0;
    do begin @(negedge clk); n++; end while (!req_ready && n < 200);
    check(n == cyc(150), "R2", "lock delay cycles", n, cyc(150));
    check(sram_ce == 1'b1, "R2", "active-high enable after lock", int'(sram_ce), 1);

    // Directed corners: extreme addresses and data.
    run_op(1, 13'h0000, 8'h00);
    run_op(1, 13'h1FFF, 8'hFF);
    run_op(0, 13'h0000, 8'h00);
    run_op(0, 13'h1FFF, 8'h00);
    run_op(1, 13'h0000, 8'hFF);
    run_op(0, 13'h0000, 8'h00);
    run_op(0, 13'h0ABC, 8'h00);  // never written: seeded value

    // R3: power lost in the middle of a read.
    req_valid = 1; req_write = 0; req_addr = 13'h0005; req_wdata = 0;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    repeat (5) @(negedge clk);
    pwr_good = 0;
    @(negedge clk);
    check(!sram_ce && sram_ce_n && sram_we_n && !sram_dq_oe, "R3", "pins after power loss",
          int'({sram_ce, sram_ce_n, sram_we_n, sram_dq_oe}), 6);
    check(!req_ready, "R3", "ready while unpowered", int'(req_ready), 0);
    rv_seen = 0;
    for (int i = 0; i < 40; i++) begin
      if (rd_valid) rv_seen++;
      @(negedge clk);
    end
    check(rv_seen == 0, "R3", "aborted read returned data", rv_seen, 0);
    pwr_good = 1;
    run_op(0, 13'h0005, 8'h00);

    // Constrained random mix.
    for (int k = 0; k < 80; k++) begin
      bit wr;
      logic [12:0] a;
      wr = 1'($urandom_range(0, 1));
      case ($urandom_range(0, 5))
        0: a = 13'h0000;
        1: a = 13'h1FFF;
        default: a = 13'($urandom_range(0, 31));
      endcase
      run_op(wr, a, 8'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "R4", "watchdog expired", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule